// File: doc/BRIEF.md
# Programmable Break Input Glitch Filter

This block cleans up a single fault input before it reaches output-protection logic. A 4-bit filter code selects how often the input is sampled and how many agreeing samples in a row are needed before the filtered level may change. Sampling runs either on every kernel clock or on every D-th pulse of a dead-time clock enable, where D is 2, 4, 8, 16 or 32. Code zero skips the filter altogether and passes the raw input straight through to the output, with no register in the path.

The code sits in a register inside the block. It is written through a strobe and a data field, and a non-zero lock level blocks any change to it. In filtered mode the raw input first crosses a two-flop synchronizer. A run counter then tracks how many consecutive samples disagree with the present output level. The output moves to the new level when the run reaches the required length. Any sample that agrees with the output clears the run, so a glitch shorter than the run length leaves no trace.

Top module: `brkflt_top`

## Requirements
- R1: With code 0 the output equals the raw input combinationally, with no clock edge in between.
- R2: Codes 1, 2 and 3 take a sample on every kernel clock and need runs of 2, 4 and 8 samples.
- R3: Codes 4 to 15 take a sample once every D dead-time enable pulses. The (D, run) pairs are: 4:(2,6) 5:(2,8) 6:(4,6) 7:(4,8) 8:(8,6) 9:(8,8) 10:(16,5) 11:(16,6) 12:(16,8) 13:(32,5) 14:(32,6) 15:(32,8).
- R4: In filtered mode the output takes a new level only when N consecutive samples have seen that level. A shorter run leaves the output unchanged.
- R5: A sample equal to the present output level clears the run, so two short runs with an agreeing sample between them never add up.
- R6: While the lock level (2 bits) is non-zero, code writes are ignored and filtering goes on under the old code.
- R7: An accepted write of a different code clears the run counter and the rate divider, and no sample is taken in that cycle.
- R8: In filtered mode the raw input passes through two synchronizer flops. At kernel rate the output therefore changes 2+N clocks after a clean input step.
- R9: Reset sets the code to 0, clears the run and the divider, and sets the filtered level to 0.
- R10: While the code is 0, the filtered level follows the synchronized input. After a switch into a filtered code, the output starts from that level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dtsEn | input | 1 | Dead-time clock enable, one pulse per dead-time period |
| rawIn | input | 1 | Unfiltered fault input |
| codeWr | input | 1 | Write strobe for the filter code |
| codeWrData | input | 4 | New filter code |
| lockLevel | input | 2 | Lock level; a non-zero value blocks code writes |
| filtOut | output | 1 | Filtered fault level |

## Verification
The hardest states to reach are the slow divided codes. With D=32 and N=8, a single level change needs hundreds of kernel clocks of steady input, while the divider phase must also line up with the moment the input changes. The stimulus holds the input steady for long random stretches under each code. It changes codes while a run is in progress, and it issues writes under lock in the middle of runs. A behavioural model compared on every clock then confirms the restart and lock behaviour in those windows.

// File: rtl/brkflt_pkg.sv
package brkflt_pkg;
  localparam int CODE_W  = 4;
  localparam int LOCK_W  = 2;
  localparam int MAX_RUN = 8;
  localparam int MAX_DIV = 32;
  localparam int RUN_W   = $clog2(MAX_RUN);
  localparam int PRE_W   = $clog2(MAX_DIV);

  typedef struct packed {
    logic             bypass;
    logic             restart;
    logic             sampleStb;
    logic [RUN_W-1:0] runLast;
  } fltCtl_t;

  typedef struct packed {
    logic             divided;
    logic [PRE_W-1:0] preLast;
    logic [RUN_W-1:0] runLast;
  } codeInfo_t;

  function automatic codeInfo_t decodeCode(input logic [CODE_W-1:0] code);
    codeInfo_t info;
    int divLog;
    int runLen;
    divLog = 0;
    runLen = 2;
    case (code)
      4'd1:  begin divLog = 0; runLen = 2; end
      4'd2:  begin divLog = 0; runLen = 4; end
      4'd3:  begin divLog = 0; runLen = 8; end
      4'd4:  begin divLog = 1; runLen = 6; end
      4'd5:  begin divLog = 1; runLen = 8; end
      4'd6:  begin divLog = 2; runLen = 6; end
      4'd7:  begin divLog = 2; runLen = 8; end
      4'd8:  begin divLog = 3; runLen = 6; end
      4'd9:  begin divLog = 3; runLen = 8; end
      4'd10: begin divLog = 4; runLen = 5; end
      4'd11: begin divLog = 4; runLen = 6; end
      4'd12: begin divLog = 4; runLen = 8; end
      4'd13: begin divLog = 5; runLen = 5; end
      4'd14: begin divLog = 5; runLen = 6; end
      4'd15: begin divLog = 5; runLen = 8; end
      default: begin divLog = 0; runLen = 2; end
    endcase
    info.divided = (divLog != 0);
    info.preLast = PRE_W'((1 << divLog) - 1);
    info.runLast = RUN_W'(runLen - 1);
    return info;
  endfunction
endpackage

// File: rtl/brkflt_ctrl.sv
module brkflt_ctrl
  import brkflt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dtsEn,
  input  logic              codeWr,
  input  logic [CODE_W-1:0] codeWrData,
  input  logic [LOCK_W-1:0] lockLevel,
  output fltCtl_t           ctl
);
  logic [CODE_W-1:0] codeReg;
  logic [PRE_W-1:0]  preCnt;
  codeInfo_t         info;
  logic              wrAccept;
  logic              divTick;

  assign info     = decodeCode(codeReg);
  assign wrAccept = codeWr && (lockLevel == '0);
  assign divTick  = dtsEn && (preCnt == info.preLast);

  always_comb begin
    ctl.bypass    = (codeReg == '0);
    ctl.restart   = wrAccept && (codeWrData != codeReg);
    ctl.runLast   = info.runLast;
    ctl.sampleStb = !ctl.bypass && !ctl.restart && (info.divided ? divTick : 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      codeReg <= '0;
    end else if (wrAccept) begin
      codeReg <= codeWrData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preCnt <= '0;
    end else if (ctl.restart || !info.divided) begin
      preCnt <= '0;
    end else if (dtsEn) begin
      preCnt <= (preCnt == info.preLast) ? '0 : preCnt + 1'b1;
    end
  end

  // R6: a locked block keeps its code
  p_lock_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lockLevel != '0) |=> $stable(codeReg));

  // R3: divider phase never passes its terminal value
  p_pre_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    preCnt <= info.preLast);

  // R3: divided rates never sample on two clocks in a row
  p_div_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.sampleStb && info.divided && !codeWr) |=> !ctl.sampleStb);
endmodule

// File: rtl/brkflt_dp.sv
module brkflt_dp
  import brkflt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    rawIn,
  input  fltCtl_t ctl,
  output logic    filtOut
);
  logic [SYNC_STAGES-1:0] syncSh;
  logic                   syncIn;
  logic                   filtLvl;
  logic [RUN_W-1:0]       runCnt;

  assign syncIn = syncSh[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syncSh <= '0;
    else        syncSh <= {syncSh[SYNC_STAGES-2:0], rawIn};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filtLvl <= 1'b0;
      runCnt  <= '0;
    end else if (ctl.bypass) begin
      filtLvl <= syncIn;
      runCnt  <= '0;
    end else if (ctl.restart) begin
      runCnt  <= '0;
    end else if (ctl.sampleStb) begin
      if (syncIn == filtLvl) begin
        runCnt <= '0;
      end else if (runCnt == ctl.runLast) begin
        filtLvl <= syncIn;
        runCnt  <= '0;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end

  assign filtOut = ctl.bypass ? rawIn : filtLvl;

  // R4: without a sample the filtered level holds
  p_hold_no_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.bypass && !ctl.sampleStb) |=> $stable(filtLvl));

  // R4: a change in filtered mode only ends a full run
  p_change_after_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ctl.bypass) && (filtLvl != $past(filtLvl)))
      |-> ($past(ctl.sampleStb) && ($past(runCnt) == $past(ctl.runLast))));

  // R5: the run never exceeds the code's length
  p_run_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.bypass |-> (runCnt <= ctl.runLast));

  // R7: a code change leaves an empty run
  p_restart_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.restart |=> (runCnt == '0));
endmodule

// File: rtl/brkflt_top.sv
module brkflt_top
  import brkflt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dtsEn,
  input  logic              rawIn,
  input  logic              codeWr,
  input  logic [CODE_W-1:0] codeWrData,
  input  logic [LOCK_W-1:0] lockLevel,
  output logic              filtOut
);
  fltCtl_t ctl;

  brkflt_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .dtsEn      (dtsEn),
    .codeWr     (codeWr),
    .codeWrData (codeWrData),
    .lockLevel  (lockLevel),
    .ctl        (ctl)
  );

  brkflt_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .rawIn   (rawIn),
    .ctl     (ctl),
    .filtOut (filtOut)
  );
endmodule

// File: tb/tb_brkflt_top.sv
`timescale 1ns/1ps
module tb_brkflt_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dtsEn = 1'b0;
  logic       rawIn = 1'b0;
  logic       codeWr = 1'b0;
  logic [3:0] codeWrData = 4'd0;
  logic [1:0] lockLevel = 2'd0;
  logic       filtOut;

  int    checks = 0;
  int    fails = 0;
  string curReq = "R9";
  bit    finished = 0;
  int    dtsPhase = 0;
  int    lfsr = 32'h1234_5678;

  // behavioural reference state
  int mCode, mS1, mS2, mPre, mCnt, mLvl;
  bit mStb, mWrOk, mRestart;

  always #2.5 clk = ~clk;

  brkflt_top dut (
    .clk(clk), .rst_n(rst_n), .dtsEn(dtsEn), .rawIn(rawIn),
    .codeWr(codeWr), .codeWrData(codeWrData), .lockLevel(lockLevel),
    .filtOut(filtOut)
  );

  function automatic int divOf(int c);
    if (c < 4)  return 1;
    if (c < 6)  return 2;
    if (c < 8)  return 4;
    if (c < 10) return 8;
    if (c < 13) return 16;
    return 32;
  endfunction

  function automatic int runOf(int c);
    case (c)
      1: return 2;  2: return 4;  3: return 8;
      4, 6, 8, 11, 14: return 6;
      10, 13: return 5;
      default: return 8;
    endcase
  endfunction

  task automatic check(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // reference model, advanced at every rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mCode = 0; mS1 = 0; mS2 = 0; mPre = 0; mCnt = 0; mLvl = 0;
    end else begin
      mWrOk    = codeWr && (lockLevel == 0);
      mRestart = mWrOk && (int'(codeWrData) != mCode);
      mStb     = (mCode < 4) ? 1'b1 : (dtsEn && (mPre == divOf(mCode) - 1));
      if (mCode == 0) begin
        mLvl = mS2; mCnt = 0;
      end else if (mRestart) begin
        mCnt = 0;
      end else if (mStb) begin
        if (mS2 == mLvl) mCnt = 0;
        else if (mCnt == runOf(mCode) - 1) begin mLvl = mS2; mCnt = 0; end
        else mCnt++;
      end
      if (mRestart || mCode < 4) mPre = 0;
      else if (dtsEn) mPre = (mPre == divOf(mCode) - 1) ? 0 : mPre + 1;
      mS2 = mS1; mS1 = int'(rawIn);
      if (mWrOk) mCode = int'(codeWrData);
    end
  end

  // dead-time enable: one pulse every third kernel clock
  always @(negedge clk) begin
    dtsPhase = (dtsPhase == 2) ? 0 : dtsPhase + 1;
    dtsEn <= (dtsPhase == 0);
  end

  // compare against the model once per clock, away from the edges
  always @(negedge clk) begin
    #1;
    if (rst_n && !finished)
      check(curReq, filtOut, (mCode == 0) ? rawIn : logic'(mLvl[0]), "model compare");
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeCode(int c);
    @(negedge clk);
    codeWr = 1'b1; codeWrData = 4'(c);
    @(negedge clk);
    codeWr = 1'b0;
  endtask

  task automatic nextRand();
    lfsr = (lfsr << 1) ^ ((lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]) ? 1 : 0);
  endtask

  initial begin
    int k;
    #20;
    check("R9", filtOut, 1'b0, "output during reset");
    @(negedge clk); rst_n = 1'b1;
    cyc(2);
    check("R9", filtOut, 1'b0, "output after reset");

    // R1: combinational bypass
    curReq = "R1";
    @(negedge clk); rawIn = 1'b1; #1;
    check("R1", filtOut, 1'b1, "bypass follows rising input");
    @(negedge clk); rawIn = 1'b0; #1;
    check("R1", filtOut, 1'b0, "bypass follows falling input");

    // R2 / R8: kernel-rate latency for code 2 (N=4)
    curReq = "R2";
    writeCode(2);
    cyc(10);
    @(negedge clk); rawIn = 1'b1;
    k = 0;
    while (k < 40) begin
      @(negedge clk); #1; k++;
      if (filtOut) break;
    end
    check("R8", logic'(k == 6), 1'b1, "latency 2+N for code 2");
    cyc(5);

    // R4 / R5: short runs under code 3 (N=8)
    curReq = "R4";
    writeCode(3);
    @(negedge clk); rawIn = 1'b0;
    cyc(20);
    check("R4", filtOut, 1'b0, "settled low under code 3");
    @(negedge clk); rawIn = 1'b1; cyc(6);
    @(negedge clk); rawIn = 1'b0; cyc(20);
    check("R4", filtOut, 1'b0, "7-sample pulse rejected");
    curReq = "R5";
    @(negedge clk); rawIn = 1'b1; cyc(6);
    @(negedge clk); rawIn = 1'b0;
    @(negedge clk); rawIn = 1'b1; cyc(6);
    @(negedge clk); rawIn = 1'b0; cyc(20);
    check("R5", filtOut, 1'b0, "two split runs do not add");
    curReq = "R4";
    @(negedge clk); rawIn = 1'b1; cyc(20);
    check("R4", filtOut, 1'b1, "full run accepted");

    // R6: locked write of code 0 is ignored
    curReq = "R6";
    @(negedge clk); lockLevel = 2'd1;
    writeCode(0);
    @(negedge clk); rawIn = 1'b0; #1;
    check("R6", filtOut, 1'b1, "locked write did not enable bypass");
    cyc(4);
    check("R6", filtOut, 1'b1, "old code still filtering");
    @(negedge clk); lockLevel = 2'd0;
    cyc(20);

    // R10: bypass tracks level, then filtering starts from it
    curReq = "R10";
    writeCode(0);
    @(negedge clk); rawIn = 1'b1; cyc(5);
    writeCode(3);
    #1;
    check("R10", filtOut, 1'b1, "filtered level tracked during bypass");
    @(negedge clk); rawIn = 1'b0; cyc(3);
    check("R10", filtOut, 1'b1, "filter holds tracked level");
    cyc(20);

    // R3: every divided code with long random holds
    curReq = "R3";
    for (int c = 1; c < 16; c++) begin
      writeCode(c);
      for (int seg = 0; seg < 6; seg++) begin
        nextRand();
        @(negedge clk); rawIn = lfsr[0];
        cyc((c < 10) ? 80 + (lfsr[9:4] % 64) : 400 + (lfsr[12:4] % 400));
      end
    end

    // R7: code changes and locked writes during runs
    curReq = "R7";
    for (int i = 0; i < 300; i++) begin
      nextRand();
      @(negedge clk);
      rawIn     = lfsr[3] ^ (lfsr[7] & lfsr[11]) ? ~rawIn : rawIn;
      lockLevel = (lfsr[5:4] == 2'd3) ? 2'd2 : 2'd0;
      codeWr    = lfsr[13:12] == 2'd0;
      codeWrData = 4'(lfsr[19:16]);
      @(negedge clk); codeWr = 1'b0;
      cyc(lfsr[24:20]);
    end
    lockLevel = 2'd0;
    cyc(10);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule